// File: doc/BRIEF.md
# Triggered Waveform Capture Controller

This block stores a stream of digitized samples in a circular capture memory. Software or a sequencer first arms it. A trigger then opens the record. A programmable number of leading samples are thrown away, and after that a programmable number of samples are written into the ring, one address per valid sample.

Once the record is complete, the block holds a done flag. It also reports the address that holds the oldest kept sample and the address of the final write. A synchronous read port lets the record be unloaded afterwards.

The write pointer keeps running from one capture to the next. Each new record therefore starts right after the previous one. A record longer than the ring overwrites its own oldest samples, and the reported start then moves so that it sits immediately after the final write.

Top module: `wave_capture_ctrl`

## Requirements
- R1: After reset the done flag is low, no write is issued, and the write address, first address and last address are all zero.
- R2: A pulse on the arm input in any state enters the waiting-for-trigger state, clears the done flag in the following cycle, and samples the discard and total counts.
- R3: A trigger is ignored unless the block is waiting for one. Triggers in idle, during discard, during capture or after completion cause no write and do not change the done flag.
- R4: After an accepted trigger, the first D valid samples are dropped without being written. D is the sampled discard count. A valid sample in the trigger cycle itself and cycles without sample-valid are not counted.
- R5: With a discard count of zero, the first valid sample after the trigger is written.
- R6: Exactly T valid samples are written, where T is the sampled total count and a total of zero counts as one. The done flag then rises in the cycle after the final write, and no further write happens until the block is re-armed.
- R7: Each write advances the write address by one, and the address wraps from DEPTH-1 to 0. A new record starts at the address that follows the previous record's final write, and at address 0 after reset.
- R8: When done, the last address equals the address of the final write. For records of at most DEPTH samples, the first address equals the address of the first kept write.
- R9: When T exceeds DEPTH, the reported first address equals the last address plus one, modulo DEPTH.
- R10: The read data output shows the memory word at the read address one clock cycle after that address is applied.
- R11: A write occurs only in a cycle with sample-valid high while capturing, and the stored word is the sample data of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse; restarts the controller |
| trig_i | input | 1 | Trigger from the test sequencer |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | DATA_W | Sample word |
| discard_cnt_i | input | CNT_W | Leading samples to drop, sampled on arm |
| total_cnt_i | input | CNT_W | Samples to keep, sampled on arm |
| wr_en_o | output | 1 | Ring write strobe |
| wr_addr_o | output | ADDR_W | Ring write pointer |
| first_addr_o | output | ADDR_W | Address of the oldest kept sample |
| last_addr_o | output | ADDR_W | Address of the final write |
| done_o | output | 1 | Record complete |
| rd_addr_i | input | ADDR_W | Unload address |
| rd_data_o | output | DATA_W | Unload data, one cycle latency |

## Verification
The bench builds the block with a 16-entry ring, 16-bit samples and 8-bit counts. With the small ring, a 20-sample record wraps the pointer and overwrites its own oldest entries within a few dozen cycles, which exercises the moved first address of R9. The small ring also lets consecutive records run across the top of the memory.

Sample streams with gaps, a sample on the trigger cycle, discard counts of zero and nonzero, a zero total, and a re-arm in the middle of a capture cover the counting rules. The written data is then read back through the unload port.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [2:0] {
      CS_IDLE    = 3'd0,
      CS_ARMED   = 3'd1,
      CS_DISCARD = 3'd2,
      CS_CAPTURE = 3'd3,
      CS_DONE    = 3'd4
   } cap_state_e;
endpackage

// File: rtl/cap_seq.sv
module cap_seq
   import cap_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DEPTH = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             trig_i,
   input  logic             smp_valid_i,
   input  logic [CNT_W-1:0] discard_i,
   input  logic [CNT_W-1:0] total_i,
   output cap_state_e       state_o,
   output logic             wr_fire_o,
   output logic             first_fire_o,
   output logic             final_fire_o,
   output logic             over_fire_o
);
   localparam logic [CNT_W:0]   DEPTH_C = (CNT_W+1)'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   cap_state_e       st_q, st_d;
   logic [CNT_W-1:0] disc_lim_q, tot_lim_q;
   logic [CNT_W-1:0] disc_cnt_q, keep_cnt_q;
   logic             disc_last;

   always_comb begin
      wr_fire_o    = (st_q == CS_CAPTURE) && smp_valid_i && !arm_i;
      first_fire_o = wr_fire_o && (keep_cnt_q == '0);
      final_fire_o = wr_fire_o && (keep_cnt_q == tot_lim_q - ONE_C);
      over_fire_o  = wr_fire_o && ({1'b0, keep_cnt_q} >= DEPTH_C);
      disc_last    = (disc_cnt_q == disc_lim_q - ONE_C);
   end

   always_comb begin
      st_d = st_q;
      if (arm_i) begin
         st_d = CS_ARMED;
      end else begin
         unique case (st_q)
            CS_ARMED:   if (trig_i) st_d = (disc_lim_q == '0) ? CS_CAPTURE : CS_DISCARD;
            CS_DISCARD: if (smp_valid_i && disc_last) st_d = CS_CAPTURE;
            CS_CAPTURE: if (final_fire_o) st_d = CS_DONE;
            default:    st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         disc_lim_q <= '0;
         tot_lim_q  <= ONE_C;
         disc_cnt_q <= '0;
         keep_cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (arm_i) begin
            disc_lim_q <= discard_i;
            tot_lim_q  <= (total_i == '0) ? ONE_C : total_i;
            disc_cnt_q <= '0;
            keep_cnt_q <= '0;
         end else begin
            if (st_q == CS_DISCARD && smp_valid_i)
               disc_cnt_q <= disc_last ? '0 : disc_cnt_q + ONE_C;
            if (wr_fire_o)
               keep_cnt_q <= keep_cnt_q + ONE_C;
         end
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/cap_wptr.sv
module cap_wptr #(
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [ADDR_W-1:0] nxt_o
);
   localparam bool_pow2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [ADDR_W-1:0] TOP_C = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q;

   generate
      if (bool_pow2) begin : g_pow2
         assign nxt_o = ptr_q + 1'b1;
      end else begin : g_cmp
         assign nxt_o = (ptr_q == TOP_C) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= nxt_o;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/cap_mark.sv
module cap_mark #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_fire_i,
   input  logic              over_fire_i,
   input  logic              final_fire_i,
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic [ADDR_W-1:0] nxt_i,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] last_o
);
   logic [ADDR_W-1:0] first_q, last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
      end else begin
         if (over_fire_i)       first_q <= nxt_i;
         else if (first_fire_i) first_q <= ptr_i;
         if (final_fire_i)      last_q  <= ptr_i;
      end
   end

   assign first_o = first_q;
   assign last_o  = last_q;
endmodule

// File: rtl/cap_ring_ram.sv
module cap_ring_ram #(
   parameter int DATA_W       = 16,
   parameter int DEPTH        = 1024,
   parameter int ADDR_W       = 10,
   parameter bit RD_REG_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] wa_i,
   input  logic [DATA_W-1:0] wd_i,
   input  logic [ADDR_W-1:0] ra_i,
   output logic [DATA_W-1:0] rd_o
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i) mem_q[wa_i] <= wd_i;
   end

   generate
      if (RD_REG_RESET) begin : g_rd_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mem_q[ra_i];
         end
      end else begin : g_rd_plain
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) rd_q <= mem_q[ra_i];
      end
   endgenerate

   assign rd_o = rd_q;
endmodule

// File: rtl/wave_capture_ctrl.sv
module wave_capture_ctrl
   import cap_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int DEPTH        = 1024,
   parameter int CNT_W        = 16,
   parameter bit RD_REG_RESET = 1'b1,
   localparam int ADDR_W      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              trig_i,
   input  logic              smp_valid_i,
   input  logic [DATA_W-1:0] smp_data_i,
   input  logic [CNT_W-1:0]  discard_cnt_i,
   input  logic [CNT_W-1:0]  total_cnt_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [ADDR_W-1:0] first_addr_o,
   output logic [ADDR_W-1:0] last_addr_o,
   output logic              done_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   generate
      if (DATA_W < 1)      begin : g_bad_dw    $error("DATA_W must be at least 1"); end
      if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (CNT_W < ADDR_W)  begin : g_bad_cnt   $error("CNT_W must cover the ring depth"); end
   endgenerate

   cap_state_e        st;
   logic              wr_fire, first_fire, final_fire, over_fire;
   logic [ADDR_W-1:0] ptr, nxt;

   cap_seq #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (arm_i),
      .trig_i       (trig_i),
      .smp_valid_i  (smp_valid_i),
      .discard_i    (discard_cnt_i),
      .total_i      (total_cnt_i),
      .state_o      (st),
      .wr_fire_o    (wr_fire),
      .first_fire_o (first_fire),
      .final_fire_o (final_fire),
      .over_fire_o  (over_fire)
   );

   cap_wptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (wr_fire),
      .ptr_o (ptr),
      .nxt_o (nxt)
   );

   cap_mark #(.ADDR_W(ADDR_W)) u_mark (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_fire_i (first_fire),
      .over_fire_i  (over_fire),
      .final_fire_i (final_fire),
      .ptr_i        (ptr),
      .nxt_i        (nxt),
      .first_o      (first_addr_o),
      .last_o       (last_addr_o)
   );

   cap_ring_ram #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RD_REG_RESET(RD_REG_RESET)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_fire),
      .wa_i  (ptr),
      .wd_i  (smp_data_i),
      .ra_i  (rd_addr_i),
      .rd_o  (rd_data_o)
   );

   assign wr_en_o   = wr_fire;
   assign wr_addr_o = ptr;
   assign done_o    = (st == CS_DONE);
endmodule

// File: rtl/cap_chk.sv
module cap_chk #(
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_i,
   input logic              smp_valid_i,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [ADDR_W-1:0] first_addr_o,
   input logic [ADDR_W-1:0] last_addr_o,
   input logic              done_o
);
   localparam logic [ADDR_W-1:0] TOP_C = ADDR_W'(DEPTH - 1);

   AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !done_o);                                                    // R2
   AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> smp_valid_i);                                              // R11
   AST_NO_WR_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !wr_en_o);                                                  // R6
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o);                                        // R6
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (wr_addr_o == (($past(wr_addr_o) == TOP_C) ? '0
                                  : $past(wr_addr_o) + 1'b1)));              // R7
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_o |=> $stable(wr_addr_o));                                      // R7
   AST_LAST_IS_FINAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (last_addr_o == $past(wr_addr_o)));                  // R8
   AST_MARKS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> ($stable(first_addr_o) && $stable(last_addr_o)));           // R8
endmodule

bind wave_capture_ctrl cap_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cap_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm_i        (arm_i),
   .smp_valid_i  (smp_valid_i),
   .wr_en_o      (wr_en_o),
   .wr_addr_o    (wr_addr_o),
   .first_addr_o (first_addr_o),
   .last_addr_o  (last_addr_o),
   .done_o       (done_o)
);

// File: tb/tb_wave_capture_ctrl.sv
`timescale 1ns/1ps
module tb_wave_capture_ctrl;
   localparam int DW = 16;
   localparam int DP = 16;
   localparam int CW = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_i = 1'b0, trig_i = 1'b0, smp_valid_i = 1'b0;
   logic [DW-1:0] smp_data_i = '0;
   logic [CW-1:0] discard_cnt_i = '0, total_cnt_i = '0;
   logic          wr_en_o, done_o;
   logic [AW-1:0] wr_addr_o, first_addr_o, last_addr_o, rd_addr_i = '0;
   logic [DW-1:0] rd_data_o;

   always #4 clk = ~clk;

   wave_capture_ctrl #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
      .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
      .discard_cnt_i(discard_cnt_i), .total_cnt_i(total_cnt_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .first_addr_o(first_addr_o),
      .last_addr_o(last_addr_o), .done_o(done_o),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   int n_chk = 0, n_bad = 0;

   function automatic void chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endfunction

   // requirement-level model: 0 idle, 1 waiting, 2 dropping, 3 storing, 4 complete
   int m_st = 0, m_disc = 0, m_tot = 1, m_dc = 0, m_kc = 0;
   int m_ptr = 0, m_first = 0, m_last = 0;
   logic [DW-1:0] shadow [DP];
   bit            sh_ok  [DP];
   logic [AW+DW-1:0] exp_q [$];

   function automatic void model_sample(logic [DW-1:0] d);
      if (m_st == 2) begin
         m_dc++;
         if (m_dc == m_disc) m_st = 3;
      end else if (m_st == 3) begin
         exp_q.push_back({AW'(m_ptr), d});
         shadow[m_ptr] = d;
         sh_ok[m_ptr]  = 1'b1;
         if (m_kc == 0)  m_first = m_ptr;
         if (m_kc >= DP) m_first = (m_ptr + 1) % DP;
         m_kc++;
         if (m_kc == m_tot) begin m_st = 4; m_last = m_ptr; end
         m_ptr = (m_ptr + 1) % DP;
      end
   endfunction

   task automatic arm(int d, int t);
      discard_cnt_i = CW'(d);
      total_cnt_i   = CW'(t);
      arm_i = 1'b1;
      m_st = 1; m_disc = d; m_tot = (t == 0) ? 1 : t; m_dc = 0; m_kc = 0;
      @(posedge clk); #1;
      arm_i = 1'b0;
   endtask

   task automatic trig(bit v, logic [DW-1:0] d);
      trig_i = 1'b1; smp_valid_i = v; smp_data_i = d;
      if (m_st == 1) m_st = (m_disc == 0) ? 3 : 2;
      else if (v)    model_sample(d);
      @(posedge clk); #1;
      trig_i = 1'b0; smp_valid_i = 1'b0;
   endtask

   task automatic send(bit v, logic [DW-1:0] d);
      smp_valid_i = v; smp_data_i = d;
      if (v) model_sample(d);
      @(posedge clk); #1;
      smp_valid_i = 1'b0;
   endtask

   task automatic readback(string tag);
      for (int a = 0; a < DP; a++) begin
         if (sh_ok[a]) begin
            rd_addr_i = AW'(a);
            @(posedge clk); #1;
            chk(rd_data_o == shadow[a], tag, int'(rd_data_o), int'(shadow[a]));
         end
      end
   endtask

   task automatic check_record(string tag);
      chk(exp_q.size() == 0, {tag, " pending writes"}, exp_q.size(), 0);
      chk(done_o == (m_st == 4), {tag, " done"}, int'(done_o), int'(m_st == 4));
      chk(int'(first_addr_o) == m_first, {tag, " first"}, int'(first_addr_o), m_first);
      chk(int'(last_addr_o) == m_last, {tag, " last"}, int'(last_addr_o), m_last);
      chk(int'(wr_addr_o) == m_ptr, {tag, " wr_addr"}, int'(wr_addr_o), m_ptr);
   endtask

   // monitor: every write must match the next expected item (R11, R7)
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R11 unexpected write", int'(wr_addr_o), -1);
         end else begin
            logic [AW+DW-1:0] it;
            it = exp_q.pop_front();
            chk(wr_addr_o == it[AW+DW-1:DW], "R7 write address",
                int'(wr_addr_o), int'(it[AW+DW-1:DW]));
            chk(smp_data_i == it[DW-1:0], "R11 write data",
                int'(smp_data_i), int'(it[DW-1:0]));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < DP; a++) sh_ok[a] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
      chk(wr_en_o == 1'b0, "R1 wr_en", int'(wr_en_o), 0);
      chk(wr_addr_o == '0 && first_addr_o == '0 && last_addr_o == '0, "R1 addresses",
          int'({wr_addr_o, first_addr_o, last_addr_o}), 0);
      @(posedge clk); #1;

      // R3: trigger while idle is ignored
      trig(1'b1, 16'hEEEE);
      for (int i = 0; i < 3; i++) send(1'b1, 16'hE000 + 16'(i));
      check_record("R3 idle trigger");

      // R4: drop two, keep four; sample on trigger cycle and gaps not counted
      arm(2, 4);
      chk(done_o == 1'b0, "R2 armed done", int'(done_o), 0);
      trig(1'b1, 16'hAAAA);
      send(1'b1, 16'h1001);
      send(1'b0, 16'hBAD0);
      send(1'b1, 16'h1002);
      trig(1'b0, 16'h0);          // R3 trigger during capture ignored
      send(1'b1, 16'h1003);
      send(1'b0, 16'hBAD1);
      send(1'b1, 16'h1004);
      send(1'b1, 16'h1005);
      send(1'b1, 16'h1006);
      check_record("R4 R6 R8 record");
      send(1'b1, 16'h1007);       // R6 no write once done
      check_record("R6 after done");
      readback("R10 readback");

      // R5: zero discard keeps the first sample; R2 arm clears done
      arm(0, 3);
      chk(done_o == 1'b0, "R2 done cleared", int'(done_o), 0);
      trig(1'b0, 16'h0);
      send(1'b1, 16'h2001);
      send(1'b0, 16'h0);
      send(1'b1, 16'h2002);
      send(1'b1, 16'h2003);
      check_record("R5 R7 zero discard");

      // R6: zero total stores one sample
      arm(1, 0);
      trig(1'b0, 16'h0);
      send(1'b1, 16'h3001);
      send(1'b1, 16'h3002);
      send(1'b1, 16'h3003);
      check_record("R6 zero total");

      // R9: record longer than the ring
      arm(0, 20);
      trig(1'b0, 16'h0);
      for (int i = 0; i < 20; i++) send(1'b1, 16'h4000 + 16'(i));
      check_record("R9 wrap");
      chk(int'(first_addr_o) == (int'(last_addr_o) + 1) % DP, "R9 adjacency",
          int'(first_addr_o), (int'(last_addr_o) + 1) % DP);
      readback("R10 R9 readback");

      // R2: re-arm in the middle of a capture restarts
      arm(0, 5);
      trig(1'b0, 16'h0);
      send(1'b1, 16'h5001);
      send(1'b1, 16'h5002);
      arm(1, 5);
      chk(done_o == 1'b0, "R2 rearm", int'(done_o), 0);
      trig(1'b0, 16'h0);
      send(1'b1, 16'h6000);
      for (int i = 1; i <= 5; i++) send(1'b1, 16'h6000 + 16'(i));
      check_record("R2 R7 restart");

      // R3: trigger after completion is ignored
      trig(1'b1, 16'h7001);
      send(1'b1, 16'h7002);
      check_record("R3 done trigger");
      readback("R10 final readback");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule